// File: doc/BRIEF.md
# Vector Predicated Branch-Condition Evaluator

This block decides a vectorised conditional branch. After a start pulse it walks the element indices from 0 up to VL-1, one index per clock. For each index it compares one condition bit against an expected polarity, and a per-element predicate mask controls which elements count. At the end it returns three results: whether the branch is taken, an updated loop counter, and a vector length that may be truncated. The surrounding branch unit captures these results on a one-cycle completion pulse.

Each element is either tested or skipped. With the zeroing option clear, an element whose predicate bit is 0 is skipped. With the zeroing option set, that element is tested using a forced zero. Two combine modes exist. In all-pass mode the first failing element decides the outcome. In any-pass mode the first passing element decides it. The walk stops at the deciding element. In counter mode the counter drops by one for each tested element. An inversion option makes it drop only for tested elements that fail. In length-setting mode the vector length is cut to just past the deciding element when the outcome matches a selected polarity. A requested length above the element capacity is clamped to that capacity.

Top module: `vbc_eval`

## Requirements
- R1: After reset, busy, done and taken are 0, and ctr_out and vl_out are 0.
- R2: With sz_in=0, an element whose predicate bit (pred_in bit i for element i) is 0 is not tested. It cannot decide the outcome and does not change the counter.
- R3: With sz_in=1, an element whose predicate bit is 0 is tested with a condition value of 0 in place of cond_in bit i. It passes when pol_in is 0.
- R4: An element passes when its condition value equals pol_in. With all_in=1, the first tested element that fails ends the walk with taken=0, and a walk with no failing tested element gives taken=1. With all_in=0, the first tested element that passes ends the walk with taken=1, and a walk with no passing tested element gives taken=0.
- R5: With ctrm_in=1 and cti_in=0, ctr_out equals ctr_in minus the number of tested elements up to and including the deciding one. With ctrm_in=0, ctr_out equals ctr_in.
- R6: With ctrm_in=1 and cti_in=1, the counter is decremented only for tested elements that fail.
- R7: The counter stops at zero and never wraps.
- R8: With vlset_in=1, when an element decides the outcome and taken equals vsb_in, vl_out becomes the deciding index plus one. In all other cases vl_out equals the requested VL.
- R9: done is a one-cycle pulse in the cycle after the deciding or last element is evaluated. With vl_in=0, done follows the start cycle directly, with taken=0, ctr_out=ctr_in and vl_out=0.
- R10: busy stays high from an accepted start until done. A start pulse while busy is ignored and does not alter the running evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation (accepted when not busy) |
| vl_in | input | VLW | Requested vector length |
| ctr_in | input | CW | Loop counter value before the branch |
| pred_in | input | N | Predicate mask, bit i for element i |
| cond_in | input | N | Condition bits, bit i for element i |
| pol_in | input | 1 | Expected condition polarity |
| all_in | input | 1 | 1: all tested must pass; 0: any one passing suffices |
| ctrm_in | input | 1 | Counter decrement mode |
| vlset_in | input | 1 | Length-setting mode |
| cti_in | input | 1 | Decrement only on failed tests |
| vsb_in | input | 1 | Truncate on taken (1) or on not taken (0) |
| sz_in | input | 1 | Test masked elements as zero |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision, valid from done |
| ctr_out | output | CW | Updated counter, valid from done |
| vl_out | output | VLW | Resulting vector length, valid from done |

## Verification
A wrong element index or a lost early stop shows up as a wrong done latency. Because done is counted from the start cycle, the error is visible at the first completion. A counter that decrements on the wrong elements, or that wraps, gives a wrong ctr_out at that same done pulse. A bad truncation shows as a vl_out that is longer than the requested length or differs from the deciding index plus one. A start that wrongly leaks into a running walk changes the result and the latency of that run.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    typedef struct packed {
        logic pol;
        logic all;
        logic ctrm;
        logic vlset;
        logic cti;
        logic vsb;
        logic sz;
    } vbc_mode_t;
endpackage

// File: rtl/vbc_elem_test.sv
module vbc_elem_test #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pred,
    input  logic [N-1:0]  cond,
    input  logic [IW-1:0] idx,
    input  logic          sz,
    input  logic          pol,
    output logic          tested,
    output logic          pass
);
    logic en_bit;
    logic value;

    always_comb begin
        en_bit = pred[idx];
        tested = en_bit | sz;
        value  = en_bit & cond[idx];
        pass   = (value == pol);
    end
endmodule

// File: rtl/vbc_ctr_step.sv
module vbc_ctr_step #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cur,
    input  logic          dec,
    output logic [CW-1:0] nxt
);
    always_comb begin
        if (dec && (cur != '0)) nxt = cur - CW'(1);
        else                     nxt = cur;
    end
endmodule

// File: rtl/vbc_decide.sv
module vbc_decide #(
    parameter int IW  = 3,
    parameter int VLW = 4
) (
    input  logic           tested,
    input  logic           pass,
    input  logic           all,
    input  logic           vlset,
    input  logic           vsb,
    input  logic [IW-1:0]  idx,
    input  logic [VLW-1:0] vl,
    output logic           finish,
    output logic           taken,
    output logic [VLW-1:0] vl_new
);
    logic decides;
    logic last;

    always_comb begin
        decides = tested && (all ? !pass : pass);
        last    = ((VLW'(idx) + VLW'(1)) == vl);
        finish  = decides || last;
        taken   = decides ? !all : all;
        if (decides && vlset && (vsb == taken)) vl_new = VLW'(idx) + VLW'(1);
        else                                    vl_new = vl;
    end
endmodule

// File: rtl/vbc_eval.sv
module vbc_eval
    import vbc_pkg::*;
#(
    parameter int N   = 8,
    parameter int CW  = 16,
    parameter int VLW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl_in,
    input  logic [CW-1:0]  ctr_in,
    input  logic [N-1:0]   pred_in,
    input  logic [N-1:0]   cond_in,
    input  logic           pol_in,
    input  logic           all_in,
    input  logic           ctrm_in,
    input  logic           vlset_in,
    input  logic           cti_in,
    input  logic           vsb_in,
    input  logic           sz_in,
    output logic           busy,
    output logic           done,
    output logic           taken,
    output logic [CW-1:0]  ctr_out,
    output logic [VLW-1:0] vl_out
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [VLW-1:0] VL_CAP = VLW'(N);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic           taken;
        logic [IW-1:0]  idx;
        logic [VLW-1:0] vl;
        logic [CW-1:0]  ctr;
        logic [N-1:0]   pred;
        logic [N-1:0]   cond;
        vbc_mode_t      mode;
        logic [VLW-1:0] vl_res;
        logic [CW-1:0]  ctr_res;
    } st_t;

    st_t st_d, st_q;

    logic           el_tested, el_pass;
    logic           ctr_dec;
    logic [CW-1:0]  ctr_nxt;
    logic           fin, fin_taken;
    logic [VLW-1:0] fin_vl;
    logic [VLW-1:0] vl_clamped;

    vbc_elem_test #(.N(N), .IW(IW)) u_test (
        .pred   (st_q.pred),
        .cond   (st_q.cond),
        .idx    (st_q.idx),
        .sz     (st_q.mode.sz),
        .pol    (st_q.mode.pol),
        .tested (el_tested),
        .pass   (el_pass)
    );

    assign ctr_dec = st_q.mode.ctrm && el_tested && (!st_q.mode.cti || !el_pass);

    vbc_ctr_step #(.CW(CW)) u_ctr (
        .cur (st_q.ctr),
        .dec (ctr_dec),
        .nxt (ctr_nxt)
    );

    vbc_decide #(.IW(IW), .VLW(VLW)) u_dec (
        .tested (el_tested),
        .pass   (el_pass),
        .all    (st_q.mode.all),
        .vlset  (st_q.mode.vlset),
        .vsb    (st_q.mode.vsb),
        .idx    (st_q.idx),
        .vl     (st_q.vl),
        .finish (fin),
        .taken  (fin_taken),
        .vl_new (fin_vl)
    );

    always_comb begin
        vl_clamped = (vl_in > VL_CAP) ? VL_CAP : vl_in;
        st_d       = st_q;
        st_d.done  = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.vl         = vl_clamped;
                st_d.ctr        = ctr_in;
                st_d.pred       = pred_in;
                st_d.cond       = cond_in;
                st_d.mode.pol   = pol_in;
                st_d.mode.all   = all_in;
                st_d.mode.ctrm  = ctrm_in;
                st_d.mode.vlset = vlset_in;
                st_d.mode.cti   = cti_in;
                st_d.mode.vsb   = vsb_in;
                st_d.mode.sz    = sz_in;
                st_d.idx        = '0;
                if (vl_clamped == '0) begin
                    st_d.done    = 1'b1;
                    st_d.taken   = 1'b0;
                    st_d.ctr_res = ctr_in;
                    st_d.vl_res  = '0;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else begin
            st_d.ctr = ctr_nxt;
            if (fin) begin
                st_d.busy    = 1'b0;
                st_d.done    = 1'b1;
                st_d.taken   = fin_taken;
                st_d.ctr_res = ctr_nxt;
                st_d.vl_res  = fin_vl;
            end else begin
                st_d.idx = st_q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign taken   = st_q.taken;
    assign ctr_out = st_q.ctr_res;
    assign vl_out  = st_q.vl_res;
endmodule

// File: rtl/vbc_eval_chk.sv
module vbc_eval_chk #(
    parameter int CW  = 16,
    parameter int VLW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [VLW-1:0] vl_in,
    input logic [CW-1:0]  ctr_in,
    input logic           ctrm_in,
    input logic           busy,
    input logic           done,
    input logic           taken,
    input logic [CW-1:0]  ctr_out,
    input logic [VLW-1:0] vl_out
);
    logic [CW-1:0]  cap_ctr;
    logic [VLW-1:0] cap_vl;
    logic           cap_ctrm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ctr  <= '0;
            cap_vl   <= '0;
            cap_ctrm <= 1'b0;
        end else if (start && !busy) begin
            cap_ctr  <= ctr_in;
            cap_vl   <= vl_in;
            cap_ctrm <= ctrm_in;
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_vl_zero_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vl_in == '0) |=> (done && !taken));
    a_r10_busy_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r10_not_busy_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_ctr_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctr_out <= cap_ctr));
    a_r5_ctr_hold_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_ctrm) |-> (ctr_out == cap_ctr));
    a_r8_vl_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= cap_vl));
endmodule

bind vbc_eval vbc_eval_chk #(.CW(CW), .VLW(VLW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vl_in   (vl_in),
    .ctr_in  (ctr_in),
    .ctrm_in (ctrm_in),
    .busy    (busy),
    .done    (done),
    .taken   (taken),
    .ctr_out (ctr_out),
    .vl_out  (vl_out)
);

// File: tb/vbc_eval_bench.sv
module vbc_eval_bench;
    localparam int N   = 8;
    localparam int CW  = 16;
    localparam int VLW = 4;
    localparam int NV  = 11;

    typedef struct packed {
        logic [3:0]  vl;
        logic [15:0] ctr;
        logic [7:0]  pred;
        logic [7:0]  cond;
        logic        pol;
        logic        all;
        logic        ctrm;
        logic        vlset;
        logic        cti;
        logic        vsb;
        logic        sz;
        logic        e_taken;
        logic [15:0] e_ctr;
        logic [3:0]  e_vl;
        logic [4:0]  e_lat;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{4'd4, 16'd10, 8'hFF, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd10, 4'd4, 5'd4},
        '{4'd4, 16'd10, 8'hFF, 8'h04, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd7,  4'd4, 5'd4},
        '{4'd4, 16'd10, 8'hFF, 8'h04, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd8,  4'd4, 5'd4},
        '{4'd5, 16'd10, 8'hFF, 8'h07, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd6,  4'd4, 5'd5},
        '{4'd6, 16'd10, 8'hF5, 8'h0A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd6,  4'd6, 5'd7},
        '{4'd6, 16'd10, 8'hF5, 8'h0A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd4,  4'd6, 5'd7},
        '{4'd4, 16'd10, 8'h0C, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'd9,  4'd1, 5'd2},
        '{4'd8, 16'd2,  8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0,  4'd8, 5'd9},
        '{4'd3, 16'd10, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd10, 4'd3, 5'd4},
        '{4'd0, 16'd10, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10, 4'd0, 5'd1},
        '{4'd5, 16'd10, 8'hFF, 8'h03, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd10, 4'd5, 5'd4}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [VLW-1:0] vl_in = '0;
    logic [CW-1:0]  ctr_in = '0;
    logic [N-1:0]   pred_in = '0;
    logic [N-1:0]   cond_in = '0;
    logic           pol_in = 1'b0, all_in = 1'b0, ctrm_in = 1'b0, vlset_in = 1'b0;
    logic           cti_in = 1'b0, vsb_in = 1'b0, sz_in = 1'b0;
    logic           busy, done, taken;
    logic [CW-1:0]  ctr_out;
    logic [VLW-1:0] vl_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vbc_eval #(.N(N), .CW(CW), .VLW(VLW)) u_vbc_eval (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .ctr_in(ctr_in),
        .pred_in(pred_in), .cond_in(cond_in), .pol_in(pol_in), .all_in(all_in),
        .ctrm_in(ctrm_in), .vlset_in(vlset_in), .cti_in(cti_in), .vsb_in(vsb_in),
        .sz_in(sz_in), .busy(busy), .done(done), .taken(taken),
        .ctr_out(ctr_out), .vl_out(vl_out)
    );

    function automatic string tag_of(int i);
        case (i)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R8";
            4: return "R2";
            5: return "R3";
            6: return "R3";
            7: return "R7";
            8: return "R4";
            9: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        vl_in = v.vl; ctr_in = v.ctr; pred_in = v.pred; cond_in = v.cond;
        pol_in = v.pol; all_in = v.all; ctrm_in = v.ctrm; vlset_in = v.vlset;
        cti_in = v.cti; vsb_in = v.vsb; sz_in = v.sz;
    endtask

    task automatic run_vec(vec_t v, string tag, bit intrude);
        int lat = 0;
        @(negedge clk);
        apply(v);
        start = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (intrude && lat == 2) begin
                check("R10", "busy mid-walk", busy, 1);
                apply(TBL[0]);
                start = 1'b1;
            end
        end while (!done && lat < 40);
        check(tag, "taken", taken, v.e_taken);
        check(tag, "ctr_out", ctr_out, v.e_ctr);
        check(tag, "vl_out", vl_out, v.e_vl);
        check("R9", "latency", lat, v.e_lat);
        @(negedge clk);
        check("R9", "done pulse width", done, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1", "busy at reset", busy, 0);
        check("R1", "done at reset", done, 0);
        check("R1", "taken at reset", taken, 0);
        check("R1", "ctr_out at reset", ctr_out, 0);
        check("R1", "vl_out at reset", vl_out, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_vec(TBL[i], tag_of(i), 1'b0);
        end

        // R10: a start during a long walk must leave that walk untouched
        run_vec(TBL[7], "R10", 1'b1);
        // R4 back-to-back after the ignored start
        run_vec(TBL[0], "R4", 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule